// File: doc/BRIEF.md
# Non-control endpoint mode and handshake register

This block keeps one control register for each non-control endpoint of a low-speed USB device. From those registers it chooses the handshake that the serial interface engine (SIE) returns to each token. Each register holds a stall bit, an acknowledged-transaction flag and a four-bit mode code. The SIE shows a token as a kind and an endpoint index, and gets back the handshake at once, in the same cycle. When a transaction ends, the SIE reports whether it ended with an ACK. The block then updates the flag, and for the one-shot modes it drops the mode back to NAK-both so the endpoint stops accepting data until firmware re-arms it.

Firmware reaches the registers over a simple byte bus. A write takes effect at the clock edge. A read returns the addressed register in the same cycle, and a read strobe clears the flag of the register it reads. The registers have no write lock. When the SIE reports a transaction end to an endpoint in the same cycle that firmware writes that endpoint, the hardware result for the mode and the flag is kept.

Top module: `epHandshakeRegs`

## Requirements
- R1: After reset every endpoint register reads 8'h00.
- R2: The register reads as {stall, 2'b00, ackFlag, mode[3:0]} (stall in bit 7, flag in bit 4, mode in bits 3:0). A firmware write stores bit 7 and bits 3:0. Written bits 6:5 and bit 4 have no effect, and bits 6:5 always read 0.
- R3: A handshake is output only while a token is presented. Mode 4'b0000 gives no handshake. Mode 4'b0001 answers NAK to both IN and OUT. Modes not listed here give no handshake. Token codes are IN=0, OUT=1, SETUP=2. Handshake codes are ACK=0, NAK=1, STALL=2.
- R4: Mode 4'b1011 answers ACK to OUT and NAK to IN.
- R5: Mode 4'b1111 answers ACK to IN and NAK to OUT.
- R6: With the stall bit set, a token that would get ACK gets STALL instead. A token that would get NAK still gets NAK.
- R7: A transaction end reported as ACKed for an OUT in mode 4'b1011 changes the mode to 4'b0001. A transaction end that was not ACKed leaves the mode unchanged.
- R8: A transaction end reported as ACKed for an IN in mode 4'b1111 changes the mode to 4'b0001. An ACKed OUT in that mode leaves the mode as it is.
- R9: Every transaction end sets the endpoint's flag to 1 if it was ACKed and to 0 if it was not.
- R10: A firmware read strobe at an endpoint's address clears that endpoint's flag from the next cycle on.
- R11: When a transaction end and a firmware write reach the same endpoint in the same cycle, the mode and flag come from the hardware update and the written mode bits are discarded. The written stall bit is still stored.
- R12: Endpoint k sits at byte address BASE_ADDR + k*ADDR_STRIDE (8'h14 and 8'h16 by default). Other addresses read 0 and ignore writes. Tokens and transaction ends reach only the endpoint they name.
- R13: A SETUP token to these endpoints gets no handshake in any mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cpuAddr | input | 8 | Firmware byte address |
| cpuWrEn | input | 1 | Firmware write strobe |
| cpuRdEn | input | 1 | Firmware read strobe (clears the flag of the addressed endpoint) |
| cpuWrData | input | 8 | Firmware write data |
| cpuRdData | output | 8 | Addressed register, combinational |
| tokValid | input | 1 | Token presented by the SIE |
| tokEp | input | EpIdxW | Endpoint index of the token |
| tokKind | input | 2 | Token kind: IN=0, OUT=1, SETUP=2 |
| hsValid | output | 1 | A handshake is to be sent |
| hsKind | output | 2 | Handshake: ACK=0, NAK=1, STALL=2 |
| xferDone | input | 1 | One-cycle pulse at the end of a transaction |
| xferEp | input | EpIdxW | Endpoint index of the ended transaction |
| xferKind | input | 2 | Token kind of the ended transaction |
| xferAcked | input | 1 | The ended transaction closed with an ACK |

## Verification
The bench uses the default parameters: two endpoints at 8'h14 and 8'h16 with a stride of 2. With two endpoints, the bench can show that a write, a read-clear or a transaction end at one endpoint leaves the other untouched. The gap address 8'h15 gives a real unmapped location between the two, so the address decode is tested on both sides of it. Same-cycle collisions between the bus and the SIE are driven on purpose, with and without an ACK, so that the hardware-wins rule can be told apart from a plain firmware write.

// File: rtl/epHandshakePkg.sv
package epHandshakePkg;

  typedef enum logic [1:0] {
    TOK_IN    = 2'd0,
    TOK_OUT   = 2'd1,
    TOK_SETUP = 2'd2
  } tokKind_e;

  typedef enum logic [1:0] {
    HS_ACK   = 2'd0,
    HS_NAK   = 2'd1,
    HS_STALL = 2'd2
  } hsKind_e;

  localparam logic [3:0] MODE_OFF        = 4'b0000;
  localparam logic [3:0] MODE_NAK_BOTH   = 4'b0001;
  localparam logic [3:0] MODE_TAKE_OUT   = 4'b1011;
  localparam logic [3:0] MODE_GIVE_IN    = 4'b1111;

  // strobes from control to the per-endpoint storage
  typedef struct packed {
    logic rdSel;   // address matches this endpoint
    logic wrEn;    // firmware write
    logic rdClr;   // firmware read strobe, clears flag
    logic hwUpd;   // SIE reports transaction end here
    logic hwAck;   // that transaction was ACKed
    logic hwFall;  // mode drops to NAK-both
  } epStrobe_t;

endpackage

// File: rtl/epRegBank.sv
module epRegBank
  import epHandshakePkg::*;
#(
  parameter int NUM_EP = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  epStrobe_t [NUM_EP-1:0]  strobes,
  input  logic [7:0]              wrData,
  output logic [NUM_EP-1:0][3:0]  epMode,
  output logic [NUM_EP-1:0]       epStall,
  output logic [NUM_EP-1:0]       epAck,
  output logic [7:0]              rdData
);

  logic [NUM_EP-1:0][7:0] regView;

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        epStall[i] <= 1'b0;
        epMode[i]  <= MODE_OFF;
        epAck[i]   <= 1'b0;
      end else begin
        if (strobes[i].wrEn) epStall[i] <= wrData[7];

        if (strobes[i].hwUpd) begin
          if (strobes[i].hwFall) epMode[i] <= MODE_NAK_BOTH;
        end else if (strobes[i].wrEn) begin
          epMode[i] <= wrData[3:0];
        end

        if (strobes[i].hwUpd)      epAck[i] <= strobes[i].hwAck;
        else if (strobes[i].rdClr) epAck[i] <= 1'b0;
      end
    end

    assign regView[i] = strobes[i].rdSel ? {epStall[i], 2'b00, epAck[i], epMode[i]} : 8'h00;
  end

  always_comb begin
    rdData = 8'h00;
    for (int i = 0; i < NUM_EP; i++) rdData = rdData | regView[i];
  end

endmodule

// File: rtl/epHsControl.sv
module epHsControl
  import epHandshakePkg::*;
#(
  parameter int NUM_EP      = 2,
  parameter int BASE_ADDR   = 8'h14,
  parameter int ADDR_STRIDE = 2,
  parameter int EpIdxW      = 1
) (
  input  logic [7:0]              cpuAddr,
  input  logic                    cpuWrEn,
  input  logic                    cpuRdEn,
  input  logic                    tokValid,
  input  logic [EpIdxW-1:0]       tokEp,
  input  logic [1:0]              tokKind,
  input  logic                    xferDone,
  input  logic [EpIdxW-1:0]       xferEp,
  input  logic [1:0]              xferKind,
  input  logic                    xferAcked,
  input  logic [NUM_EP-1:0][3:0]  epMode,
  input  logic [NUM_EP-1:0]       epStall,
  output epStrobe_t [NUM_EP-1:0]  strobes,
  output logic                    hsValid,
  output logic [1:0]              hsKind
);

  for (genvar i = 0; i < NUM_EP; i++) begin : g_dec
    localparam logic [7:0] EpAddr = 8'(BASE_ADDR + i * ADDR_STRIDE);
    logic addrHit;
    logic xferHit;
    assign addrHit = (cpuAddr == EpAddr);
    assign xferHit = xferDone && (xferEp == EpIdxW'(i));

    assign strobes[i].rdSel  = addrHit;
    assign strobes[i].wrEn   = cpuWrEn && addrHit;
    assign strobes[i].rdClr  = cpuRdEn && addrHit;
    assign strobes[i].hwUpd  = xferHit;
    assign strobes[i].hwAck  = xferAcked;
    assign strobes[i].hwFall = xferAcked &&
      ((epMode[i] == MODE_TAKE_OUT && xferKind == TOK_OUT) ||
       (epMode[i] == MODE_GIVE_IN  && xferKind == TOK_IN));
  end

  logic       selHit;
  logic [3:0] selMode;
  logic       selStall;

  always_comb begin
    selHit   = 1'b0;
    selMode  = MODE_OFF;
    selStall = 1'b0;
    for (int i = 0; i < NUM_EP; i++) begin
      if (tokEp == EpIdxW'(i)) begin
        selHit   = 1'b1;
        selMode  = epMode[i];
        selStall = epStall[i];
      end
    end
  end

  logic     wantAck;
  logic     wantNak;
  hsKind_e  hsPick;

  always_comb begin
    wantAck = 1'b0;
    wantNak = 1'b0;
    if (tokValid && selHit && tokKind != TOK_SETUP) begin
      unique case (selMode)
        MODE_NAK_BOTH: wantNak = 1'b1;
        MODE_TAKE_OUT: begin
          wantAck = (tokKind == TOK_OUT);
          wantNak = (tokKind == TOK_IN);
        end
        MODE_GIVE_IN: begin
          wantAck = (tokKind == TOK_IN);
          wantNak = (tokKind == TOK_OUT);
        end
        default: ;
      endcase
    end
    if (wantAck) hsPick = selStall ? HS_STALL : HS_ACK;
    else         hsPick = HS_NAK;
  end

  assign hsValid = wantAck || wantNak;
  assign hsKind  = hsValid ? hsPick : HS_ACK;

endmodule

// File: rtl/epHandshakeRegs.sv
module epHandshakeRegs
  import epHandshakePkg::*;
#(
  parameter int NUM_EP      = 2,
  parameter int BASE_ADDR   = 8'h14,
  parameter int ADDR_STRIDE = 2,
  localparam int EpIdxW     = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        cpuAddr,
  input  logic              cpuWrEn,
  input  logic              cpuRdEn,
  input  logic [7:0]        cpuWrData,
  output logic [7:0]        cpuRdData,
  input  logic              tokValid,
  input  logic [EpIdxW-1:0] tokEp,
  input  logic [1:0]        tokKind,
  output logic              hsValid,
  output logic [1:0]        hsKind,
  input  logic              xferDone,
  input  logic [EpIdxW-1:0] xferEp,
  input  logic [1:0]        xferKind,
  input  logic              xferAcked
);

  epStrobe_t [NUM_EP-1:0]  strobes;
  logic [NUM_EP-1:0][3:0]  epMode;
  logic [NUM_EP-1:0]       epStall;
  logic [NUM_EP-1:0]       epAck;

  epHsControl #(
    .NUM_EP(NUM_EP), .BASE_ADDR(BASE_ADDR),
    .ADDR_STRIDE(ADDR_STRIDE), .EpIdxW(EpIdxW)
  ) u_ctrl (
    .cpuAddr(cpuAddr), .cpuWrEn(cpuWrEn), .cpuRdEn(cpuRdEn),
    .tokValid(tokValid), .tokEp(tokEp), .tokKind(tokKind),
    .xferDone(xferDone), .xferEp(xferEp), .xferKind(xferKind), .xferAcked(xferAcked),
    .epMode(epMode), .epStall(epStall),
    .strobes(strobes), .hsValid(hsValid), .hsKind(hsKind)
  );

  epRegBank #(.NUM_EP(NUM_EP)) u_bank (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(cpuWrData),
    .epMode(epMode), .epStall(epStall), .epAck(epAck), .rdData(cpuRdData)
  );

endmodule

// File: rtl/epHandshakeChk.sv
module epHandshakeChk
  import epHandshakePkg::*;
#(
  parameter int NUM_EP = 2,
  parameter int EpIdxW = 1
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [7:0]              cpuRdData,
  input logic                    tokValid,
  input logic [EpIdxW-1:0]       tokEp,
  input logic [1:0]              tokKind,
  input logic                    hsValid,
  input logic [1:0]              hsKind,
  input logic                    xferDone,
  input logic [EpIdxW-1:0]       xferEp,
  input logic [1:0]              xferKind,
  input logic                    xferAcked,
  input logic [NUM_EP-1:0][3:0]  epMode,
  input logic [NUM_EP-1:0]       epStall,
  input logic [NUM_EP-1:0]       epAck
);

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    cpuRdData[6:5] == 2'b00);

  a_r3_hs_needs_token: assert property (@(posedge clk) disable iff (!rstN)
    !tokValid |-> !hsValid);

  a_r13_setup_silent: assert property (@(posedge clk) disable iff (!rstN)
    (tokValid && tokKind == TOK_SETUP) |-> !hsValid);

  a_r6_stall_blocks_ack: assert property (@(posedge clk) disable iff (!rstN)
    (hsValid && hsKind == HS_ACK) |-> !epStall[tokEp]);

  a_r7_out_fallback: assert property (@(posedge clk) disable iff (!rstN)
    (xferDone && xferAcked && xferKind == TOK_OUT && epMode[xferEp] == MODE_TAKE_OUT)
    |=> epMode[$past(xferEp)] == MODE_NAK_BOTH);

  a_r8_in_fallback: assert property (@(posedge clk) disable iff (!rstN)
    (xferDone && xferAcked && xferKind == TOK_IN && epMode[xferEp] == MODE_GIVE_IN)
    |=> epMode[$past(xferEp)] == MODE_NAK_BOTH);

  a_r9_flag_set: assert property (@(posedge clk) disable iff (!rstN)
    (xferDone && xferAcked) |=> epAck[$past(xferEp)]);

  a_r9_flag_clear: assert property (@(posedge clk) disable iff (!rstN)
    (xferDone && !xferAcked) |=> !epAck[$past(xferEp)]);

endmodule

bind epHandshakeRegs epHandshakeChk #(.NUM_EP(NUM_EP), .EpIdxW(EpIdxW)) u_chk (
  .clk(clk), .rstN(rstN), .cpuRdData(cpuRdData),
  .tokValid(tokValid), .tokEp(tokEp), .tokKind(tokKind),
  .hsValid(hsValid), .hsKind(hsKind),
  .xferDone(xferDone), .xferEp(xferEp), .xferKind(xferKind), .xferAcked(xferAcked),
  .epMode(epMode), .epStall(epStall), .epAck(epAck)
);

// File: tb/epHandshakeRegs_tb.sv
`timescale 1ns/1ps
module epHandshakeRegs_tb;

  localparam logic [7:0] A0 = 8'h14;
  localparam logic [7:0] A1 = 8'h16;
  localparam logic [1:0] T_IN = 2'd0, T_OUT = 2'd1, T_SETUP = 2'd2;
  localparam logic [2:0] H_NONE = 3'b000, H_ACK = 3'b100, H_NAK = 3'b101, H_STALL = 3'b110;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] cpuAddr = 8'h00;
  logic cpuWrEn = 1'b0, cpuRdEn = 1'b0;
  logic [7:0] cpuWrData = 8'h00;
  logic [7:0] cpuRdData;
  logic tokValid = 1'b0;
  logic [0:0] tokEp = 1'b0;
  logic [1:0] tokKind = 2'd0;
  logic hsValid;
  logic [1:0] hsKind;
  logic xferDone = 1'b0;
  logic [0:0] xferEp = 1'b0;
  logic [1:0] xferKind = 2'd0;
  logic xferAcked = 1'b0;

  int nChecks = 0;
  int nFails = 0;

  always #2.5 clk = ~clk;

  epHandshakeRegs u_dut (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrEn(cpuWrEn), .cpuRdEn(cpuRdEn),
    .cpuWrData(cpuWrData), .cpuRdData(cpuRdData),
    .tokValid(tokValid), .tokEp(tokEp), .tokKind(tokKind),
    .hsValid(hsValid), .hsKind(hsKind),
    .xferDone(xferDone), .xferEp(xferEp), .xferKind(xferKind), .xferAcked(xferAcked)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic cpuWrite(input logic [7:0] addr, input logic [7:0] data);
    @(negedge clk);
    cpuAddr = addr; cpuWrData = data; cpuWrEn = 1'b1;
    @(negedge clk);
    cpuWrEn = 1'b0;
  endtask

  task automatic readCheck(input logic [7:0] addr, input logic [7:0] exp, input string req);
    @(negedge clk);
    cpuAddr = addr;
    #1 check(req, cpuRdData, exp);
  endtask

  task automatic readStrobe(input logic [7:0] addr);
    @(negedge clk);
    cpuAddr = addr; cpuRdEn = 1'b1;
    @(negedge clk);
    cpuRdEn = 1'b0;
  endtask

  task automatic tokCheck(input logic ep, input logic [1:0] kind, input logic [2:0] exp, input string req);
    @(negedge clk);
    tokEp = ep; tokKind = kind; tokValid = 1'b1;
    #1 check(req, {5'b0, hsValid, hsValid ? hsKind : 2'b00}, {5'b0, exp});
    tokValid = 1'b0;
  endtask

  task automatic xferEnd(input logic ep, input logic [1:0] kind, input logic acked);
    @(negedge clk);
    xferEp = ep; xferKind = kind; xferAcked = acked; xferDone = 1'b1;
    @(negedge clk);
    xferDone = 1'b0;
  endtask

  task automatic testReset();
    readCheck(A0, 8'h00, "R1 ep0 reset");
    readCheck(A1, 8'h00, "R1 ep1 reset");
    tokCheck(1'b0, T_OUT, H_NONE, "R3 mode off OUT");
    tokCheck(1'b0, T_IN,  H_NONE, "R3 mode off IN");
  endtask

  task automatic testLayout();
    cpuWrite(A0, 8'hFF);
    readCheck(A0, 8'h8F, "R2 reserved and flag writes ignored");
    cpuWrite(A0, 8'h01);
    readCheck(A0, 8'h01, "R2 stall cleared by write");
  endtask

  task automatic testModes();
    tokCheck(1'b0, T_IN,    H_NAK,  "R3 nak-both IN");
    tokCheck(1'b0, T_OUT,   H_NAK,  "R3 nak-both OUT");
    tokCheck(1'b0, T_SETUP, H_NONE, "R13 SETUP nak-both");
    cpuWrite(A0, 8'h05);
    tokCheck(1'b0, T_IN,    H_NONE, "R3 unlisted mode");
    cpuWrite(A0, 8'h0B);
    tokCheck(1'b0, T_OUT,   H_ACK,  "R4 OUT acked");
    tokCheck(1'b0, T_IN,    H_NAK,  "R4 IN naked");
    tokCheck(1'b0, T_SETUP, H_NONE, "R13 SETUP take-out");
    cpuWrite(A0, 8'h0F);
    tokCheck(1'b0, T_IN,    H_ACK,  "R5 IN acked");
    tokCheck(1'b0, T_OUT,   H_NAK,  "R5 OUT naked");
  endtask

  task automatic testStall();
    cpuWrite(A0, 8'h8B);
    tokCheck(1'b0, T_OUT, H_STALL, "R6 OUT stalled");
    tokCheck(1'b0, T_IN,  H_NAK,   "R6 IN stays nak");
    cpuWrite(A0, 8'h8F);
    tokCheck(1'b0, T_IN,  H_STALL, "R6 IN stalled");
    tokCheck(1'b0, T_OUT, H_NAK,   "R6 OUT stays nak");
  endtask

  task automatic testFallback();
    cpuWrite(A0, 8'h0B);
    xferEnd(1'b0, T_OUT, 1'b1);
    readCheck(A0, 8'h11, "R7 OUT ack falls back, R9 flag set");
    tokCheck(1'b0, T_OUT, H_NAK, "R7 nak after fallback");
    readStrobe(A0);
    readCheck(A0, 8'h01, "R10 read clears flag");
    cpuWrite(A0, 8'h0B);
    xferEnd(1'b0, T_OUT, 1'b0);
    readCheck(A0, 8'h0B, "R7 no ack keeps mode, R9 flag 0");
    cpuWrite(A0, 8'h0F);
    xferEnd(1'b0, T_OUT, 1'b1);
    readCheck(A0, 8'h1F, "R8 OUT ack in give-in keeps mode");
    xferEnd(1'b0, T_IN, 1'b1);
    readCheck(A0, 8'h11, "R8 IN ack falls back");
    xferEnd(1'b0, T_IN, 1'b0);
    readCheck(A0, 8'h01, "R9 flag cleared by non-acked end");
  endtask

  task automatic testCollision();
    cpuWrite(A0, 8'h0B);
    @(negedge clk);
    cpuAddr = A0; cpuWrData = 8'h8F; cpuWrEn = 1'b1;
    xferEp = 1'b0; xferKind = T_OUT; xferAcked = 1'b1; xferDone = 1'b1;
    @(negedge clk);
    cpuWrEn = 1'b0; xferDone = 1'b0;
    readCheck(A0, 8'h91, "R11 hw fallback wins, stall written");
    cpuWrite(A0, 8'h0B);
    @(negedge clk);
    cpuAddr = A0; cpuWrData = 8'h0F; cpuWrEn = 1'b1;
    xferEp = 1'b0; xferKind = T_OUT; xferAcked = 1'b0; xferDone = 1'b1;
    @(negedge clk);
    cpuWrEn = 1'b0; xferDone = 1'b0;
    readCheck(A0, 8'h0B, "R11 hw keeps mode over write");
  endtask

  task automatic testAddressing();
    cpuWrite(A1, 8'h0F);
    readCheck(A1, 8'h0F, "R12 ep1 at second address");
    readCheck(A0, 8'h0B, "R12 ep0 untouched by ep1 write");
    cpuWrite(8'h15, 8'hFF);
    readCheck(8'h15, 8'h00, "R12 gap address reads zero");
    readCheck(A0, 8'h0B, "R12 gap write ignored ep0");
    readCheck(A1, 8'h0F, "R12 gap write ignored ep1");
    tokCheck(1'b1, T_IN,  H_ACK, "R12 ep1 token uses ep1 mode");
    tokCheck(1'b0, T_IN,  H_NAK, "R12 ep0 token uses ep0 mode");
    xferEnd(1'b1, T_IN, 1'b1);
    readCheck(A1, 8'h11, "R12 ep1 transaction end");
    readCheck(A0, 8'h0B, "R12 ep0 unaffected by ep1 end");
    readStrobe(A0);
    readCheck(A1, 8'h11, "R12 ep0 read leaves ep1 flag");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testLayout();
    testModes();
    testStall();
    testFallback();
    testCollision();
    testAddressing();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule